// File: doc/BRIEF.md
# Noise-Shaping Requantiser with Segmented Current-DAC Encoder

This block sits between a four-times upsampling filter and a segmented current-steering DAC. On every strobe at four times the audio rate it takes one 22-bit two's complement sample and reduces it to a 15-bit two's complement word. The seven bits that are dropped are not thrown away. They are kept as a residue and added to the next sample before it is reduced. This first-order error feedback pushes the requantisation noise towards high frequencies, with a noise transfer of 1 - z^-1.

The 15-bit word is then split into the controls of the current DAC. One bit sets the direction of the output current. The magnitude is divided into a 5-bit coarse part and a 9-bit fine part. The coarse part is expanded into a 32-line thermometer code that switches the coarse current sources. The fine part selects a fraction of one coarse current. All three fields are registered and change only on the strobe. Reset clears the residue and puts the code for zero on the outputs.

Top module: `dac_ns_segmenter`

## Requirements
- R1: The output fields change only at a rising clock edge where `stb_i` is high. At every other edge they hold their value.
- R2: On a strobe without saturation, the word is floor((sample + residue) / 128). The new residue is the low 7 bits of that sum, read as an unsigned value from 0 to 127. The residue starts at 0.
- R3: If floor((sample + residue) / 128) falls outside -16383..+16383, the word is clamped to the nearer limit and the residue keeps its old value. The word is never -16384.
- R4: `dac_dir_o` is 1 exactly when the word is negative.
- R5: The magnitude is the absolute value of the word, from 0 to 16383. Bit k of `dac_therm_o` is 1 exactly when k < floor(magnitude / 512), so the code always has the form 0...01...1. Line 31 is never driven high.
- R6: `dac_fine_o` equals the magnitude modulo 512.
- R7: A word of zero gives `dac_dir_o`=0, `dac_therm_o`=0 and `dac_fine_o`=0. A negative zero is never produced.
- R8: While `rst_i` is high, the outputs are 0, 0 and 0 and the residue is cleared. The first strobe after reset therefore sees a residue of 0.
- R9: With a constant input of 64 (half of one output step), successive words alternate between two adjacent values, so the mean of the output tracks the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stb_i | input | 1 | Sample strobe at four times the audio rate |
| sample_i | input | 22 | Filtered sample, two's complement |
| dac_dir_o | output | 1 | Current direction (1 = negative word) |
| dac_therm_o | output | 32 | Coarse current source enables, thermometer code |
| dac_fine_o | output | 9 | Fine fraction select |

## Verification
The assertions check on every cycle that the fields hold between strobes, that the coarse code stays a thermometer, that a set direction bit never comes with a zero magnitude, that the clamped word never reaches -16384, and that the residue is frozen on a saturated strobe. The arithmetic itself can only be shown by the bench's scenarios. These cover the chain of residues carried across a sequence of samples, the floor rounding of negative sums, the way a saturated strobe leaves the next result unchanged, the clearing of the residue by reset, and the alternating pattern produced by a half-step input.

// File: rtl/dac_ns_pkg.sv
package dac_ns_pkg;
  localparam int unsigned DEF_IN_W   = 22;
  localparam int unsigned DEF_OUT_W  = 15;
  localparam int unsigned DEF_FINE_W = 9;
endpackage

// File: rtl/ns_requant.sv
module ns_requant #(
  parameter int unsigned IN_W  = dac_ns_pkg::DEF_IN_W,
  parameter int unsigned OUT_W = dac_ns_pkg::DEF_OUT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    stb_i,
  input  logic [IN_W-1:0]         sample_i,
  output logic signed [OUT_W-1:0] word_o,
  output logic                    sat_o
);
  localparam int unsigned DROP_W = IN_W - OUT_W;
  localparam int unsigned SUM_W  = IN_W + 1;
  localparam int unsigned Q_W    = SUM_W - DROP_W;
  localparam logic signed [Q_W-1:0] QMAX = Q_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [Q_W-1:0] QMIN = -QMAX;

  logic [DROP_W-1:0]       err_q;
  logic signed [SUM_W-1:0] sum_w;
  logic signed [Q_W-1:0]   q_w;
  logic                    sat_hi_w, sat_lo_w;

  function automatic logic signed [SUM_W-1:0] add_residue(
    input logic [IN_W-1:0] x, input logic [DROP_W-1:0] r);
    logic signed [SUM_W-1:0] xs, rs;
    xs = $signed({x[IN_W-1], x});
    rs = $signed({{(SUM_W-DROP_W){1'b0}}, r});
    return xs + rs;
  endfunction

  assign sum_w    = add_residue(sample_i, err_q);
  assign q_w      = sum_w[SUM_W-1:DROP_W];
  assign sat_hi_w = (q_w > QMAX);
  assign sat_lo_w = (q_w < QMIN);
  assign sat_o    = sat_hi_w | sat_lo_w;

  always_comb begin
    if (sat_hi_w)      word_o = QMAX[OUT_W-1:0];
    else if (sat_lo_w) word_o = QMIN[OUT_W-1:0];
    else               word_o = q_w[OUT_W-1:0];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)                err_q <= '0;
    else if (stb_i && !sat_o) err_q <= sum_w[DROP_W-1:0];
  end

  // R3: residue frozen on a saturated strobe
  a_r3_err_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && sat_o) |=> $stable(err_q));

  // R3: clamped word never reaches the most negative code
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (rst_i)
    word_o != {1'b1, {(OUT_W-1){1'b0}}});
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder #(
  parameter int unsigned OUT_W  = dac_ns_pkg::DEF_OUT_W,
  parameter int unsigned FINE_W = dac_ns_pkg::DEF_FINE_W
) (
  input  logic signed [OUT_W-1:0]                   word_i,
  output logic                                      dir_o,
  output logic [(2 ** (OUT_W-1-FINE_W))-1:0]        therm_o,
  output logic [FINE_W-1:0]                         fine_o
);
  localparam int unsigned MAG_W    = OUT_W - 1;
  localparam int unsigned COARSE_W = MAG_W - FINE_W;
  localparam int unsigned LINES    = 2 ** COARSE_W;

  function automatic logic [MAG_W-1:0] magnitude(input logic signed [OUT_W-1:0] w);
    logic signed [OUT_W-1:0] n;
    n = -w;
    return w[OUT_W-1] ? n[MAG_W-1:0] : w[MAG_W-1:0];
  endfunction

  logic [MAG_W-1:0]    mag_w;
  logic [COARSE_W-1:0] coarse_w;

  assign mag_w    = magnitude(word_i);
  assign coarse_w = mag_w[MAG_W-1:FINE_W];
  assign fine_o   = mag_w[FINE_W-1:0];
  assign dir_o    = word_i[OUT_W-1];

  for (genvar k = 0; k < LINES; k++) begin : g_line
    assign therm_o[k] = ({1'b0, coarse_w} > (COARSE_W+1)'(k));
  end
endmodule

// File: rtl/dac_ns_segmenter.sv
module dac_ns_segmenter #(
  parameter int unsigned IN_W   = dac_ns_pkg::DEF_IN_W,
  parameter int unsigned OUT_W  = dac_ns_pkg::DEF_OUT_W,
  parameter int unsigned FINE_W = dac_ns_pkg::DEF_FINE_W
) (
  input  logic                                   clk_i,
  input  logic                                   rst_i,
  input  logic                                   stb_i,
  input  logic [IN_W-1:0]                        sample_i,
  output logic                                   dac_dir_o,
  output logic [(2 ** (OUT_W-1-FINE_W))-1:0]     dac_therm_o,
  output logic [FINE_W-1:0]                      dac_fine_o
);
  localparam int unsigned LINES = 2 ** (OUT_W - 1 - FINE_W);

  logic signed [OUT_W-1:0] word_w;
  logic                    sat_w;
  logic                    dir_w;
  logic [LINES-1:0]        therm_w;
  logic [FINE_W-1:0]       fine_w;

  ns_requant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_requant (
    .clk_i(clk_i), .rst_i(rst_i), .stb_i(stb_i), .sample_i(sample_i),
    .word_o(word_w), .sat_o(sat_w)
  );

  seg_encoder #(.OUT_W(OUT_W), .FINE_W(FINE_W)) u_enc (
    .word_i(word_w), .dir_o(dir_w), .therm_o(therm_w), .fine_o(fine_w)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dac_dir_o   <= 1'b0;
      dac_therm_o <= '0;
      dac_fine_o  <= '0;
    end else if (stb_i) begin
      dac_dir_o   <= dir_w;
      dac_therm_o <= therm_w;
      dac_fine_o  <= fine_w;
    end
  end

  // R1: fields hold between strobes
  a_r1_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !stb_i |=> ($stable(dac_dir_o) && $stable(dac_therm_o) && $stable(dac_fine_o)));

  // R5: coarse code is always a thermometer with the top line off
  a_r5_therm_shape: assert property (@(posedge clk_i) disable iff (rst_i)
    (((dac_therm_o + 1'b1) & dac_therm_o) == '0) && !dac_therm_o[LINES-1]);

  // R7: no negative zero
  a_r7_no_neg_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    dac_dir_o |-> ((|dac_therm_o) || (|dac_fine_o)));

  // R3: a saturated strobe latches a full-scale magnitude
  a_r3_sat_full: assert property (@(posedge clk_i) disable iff (rst_i)
    (stb_i && sat_w) |=> ((&dac_fine_o) && (&dac_therm_o[LINES-2:0])));
endmodule

// File: tb/test_dac_ns_segmenter.sv
module test_dac_ns_segmenter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stb = 1'b0;
  logic [21:0] sample = '0;
  logic        dir;
  logic [31:0] therm;
  logic [8:0]  fine;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  dac_ns_segmenter i_dac_ns_segmenter (
    .clk_i(clk), .rst_i(rst), .stb_i(stb), .sample_i(sample),
    .dac_dir_o(dir), .dac_therm_o(therm), .dac_fine_o(fine)
  );

  localparam int VEC_N = 16;
  localparam int TV_X [VEC_N] = '{0, 128, 200, 100, -1, -300, 1, 2097151,
                                  2097151, -2097152, -2097152, -129, -126,
                                  5000, -70000, 600000};
  localparam int TV_W [VEC_N] = '{0, 1, 1, 1, 0, -3, 1, 16383,
                                  16383, -16383, -16383, -1, 0,
                                  39, -547, 4687};

  task automatic check_word(input int w, input string tag);
    logic        e_dir;
    logic [31:0] e_therm;
    logic [8:0]  e_fine;
    int          m;
    int          c;
    m       = (w < 0) ? -w : w;
    c       = m / 512;
    e_dir   = (w < 0);
    e_fine  = 9'(m % 512);
    e_therm = 32'((64'd1 << c) - 64'd1);
    checks++;
    if (dir !== e_dir || therm !== e_therm || fine !== e_fine) begin
      errors++;
      $display("FAIL %s: word %0d got dir=%b therm=%h fine=%0d expected dir=%b therm=%h fine=%0d",
               tag, w, dir, therm, fine, e_dir, e_therm, e_fine);
    end
  endtask

  task automatic apply(input int x);
    @(negedge clk);
    sample = 22'(x);
    stb    = 1'b1;
    @(negedge clk);
    stb    = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_word(0, "R8 reset outputs");
    rst = 1'b0;

    // Table walk: R2 residue chain, R3 saturation, R4/R5/R6 fields, R7 zero
    for (int i = 0; i < VEC_N; i++) begin
      apply(TV_X[i]);
      check_word(TV_W[i], $sformatf("R2/R3/R4/R5/R6/R7 vector %0d", i));
    end

    // R1: no strobe, changed input, outputs hold
    @(negedge clk);
    sample = 22'(-2097152);
    repeat (4) @(negedge clk);
    check_word(4687, "R1 hold without strobe");

    // R8: reset mid-run with residue 88, then first strobe sees residue 0
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_word(0, "R8 reset outputs mid-run");
    rst = 1'b0;
    apply(40);
    check_word(0, "R8 residue cleared");

    // R9: half-step input alternates 0,1 (residue 40 on entry)
    for (int k = 0; k < 8; k++) begin
      apply(64);
      check_word(k % 2, "R9 alternation");
    end

    // R4/R6: small negative after the sequence (residue 40+64*... state: 40)
    apply(-168);
    check_word(-1, "R4 small negative");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule